// File: doc/BRIEF.md
# Packet Data Port Arbiter

This block sits between a host data register and a pair of 32-bit packet FIFOs. One FIFO is filled by the host and drained by the transmit side. The other is filled by the receive side and drained by the host. The host may read or write the data register one byte, two bytes or four bytes at a time, in any mix. Inside the block, a lane pointer for each direction tracks where the next host byte falls inside a 32-bit entry. Writes are packed into whole entries before they are pushed, and reads are taken from the head entries, which are popped only once their last byte has been consumed. An access may straddle two entries.

The host uses asynchronous read and write strobes. Before a strobe starts, the register is selected by presenting an address that a transparent latch captures, closing on the rising edge of the address strobe. A separate data chip-select selects the data register directly, without address decoding, for DMA-style streaming; such accesses are always treated as 32-bit. A hit on the data register raises the hold output straight from the strobe's leading edge. The internal clock lowers hold once the FIFO state lets the access finish.

Top module: `pdp_arbiter`

## Requirements
- R1: The address latch follows `addr_i` while `ads_n_i` is low and holds its value after `ads_n_i` rises, so address changes during the strobe do not alter the decode.
- R2: `hold_o` goes high combinationally when `rd_n_i` or `wr_n_i` falls while the data register is selected, either by latched address equal to `DATA_ADDR` or by `data_cs_n_i` low.
- R3: `hold_o` is released by the internal clock within four clock cycles of the strobe once the access can complete, stays low until the strobe ends, and each strobe moves data at most once.
- R4: Host writes are packed from byte lane 0 upward, with the first byte in bits 7:0. An entry is pushed to the transmit FIFO only when its lane 3 is filled.
- R5: A write that crosses an entry boundary pushes the completed entry and keeps the remaining bytes from lane 0 of the next entry. `size_i` encodes 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes, taken from the low bytes of `wdata_i`.
- R6: A write that would complete an entry while the transmit FIFO is full keeps `hold_o` high until an entry drains. A write that completes no entry finishes even when the FIFO is full.
- R7: Host reads return bytes from the current lane pointer, right-justified in `rdata_o` with the upper bytes zero. The head entry is popped only when its lane 3 is consumed.
- R8: A read that needs more receive entries than are present, which is two if it crosses an entry boundary, keeps `hold_o` high until enough entries arrive.
- R9: With `data_cs_n_i` low, every access is 4 bytes regardless of `size_i` and the latched address.
- R10: Strobes that select no data register leave `hold_o` low and change neither FIFO nor any lane pointer.
- R11: Each FIFO holds `DEPTH` (default 4) entries. `rx_ready_o` is low exactly when the receive FIFO is full, and `tx_valid_o` is high whenever the transmit FIFO is not empty.
- R12: After reset, `hold_o` and `tx_valid_o` are low, `rx_ready_o` is high, and both lane pointers are at lane 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ads_n_i | input | 1 | Address strobe; latch closes on its rising edge |
| addr_i | input | AW | Host register address |
| rd_n_i | input | 1 | Host read strobe, active low |
| wr_n_i | input | 1 | Host write strobe, active low |
| data_cs_n_i | input | 1 | Direct data chip-select, active low, forces 32-bit |
| size_i | input | 2 | Access size: 0 byte, 1 halfword, 2/3 word |
| wdata_i | input | 32 | Host write data, right-justified |
| rdata_o | output | 32 | Host read data, right-justified |
| hold_o | output | 1 | High: extend the current host cycle |
| tx_data_o | output | 32 | Transmit FIFO head entry |
| tx_valid_o | output | 1 | Transmit FIFO not empty |
| tx_ready_i | input | 1 | Transmit side takes the head entry |
| rx_data_i | input | 32 | Receive entry to store |
| rx_valid_i | input | 1 | Receive entry present |
| rx_ready_o | output | 1 | Receive FIFO has space |

## Verification
The bench drives a byte, then a word, then a halfword, then a byte, so that writes straddle entry boundaries. A design that shifted the leftover bytes wrongly, or pushed one write too early or too late, would show a wrong entry at the transmit port. It fills the transmit FIFO and then issues two writes. The first, a byte write that completes no entry, must go through. The second, a word write that completes an entry, must hold until space frees; a design that judged fullness per access instead of per completed entry would hang the first or overrun the second. On the read side it checks that the receive FIFO is not popped until lane 3 is consumed, visible on `rx_ready_o`. It also checks that a straddling read takes its upper bytes from the second entry, and that a read on an empty FIFO is released only after an entry arrives. It checks that the direct chip-select ignores `size_i`, that address changes after the latch closes are ignored, and that strobes to other addresses leave the lane state untouched.

// File: rtl/pdp_pkg.sv
package pdp_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } pdp_size_e;

  // byte count of a host access; reserved code behaves as a word
  function automatic logic [2:0] size_bytes(logic [1:0] sz);
    case (pdp_size_e'(sz))
      SZ_BYTE: return 3'd1;
      SZ_HALF: return 3'd2;
      default: return 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/pdp_addr_latch.sv
module pdp_addr_latch #(
  parameter int AW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ads_n_i,
  input  logic [AW-1:0] addr_i,
  output logic [AW-1:0] addr_o
);
  always_latch begin
    if (!rst_ni)       addr_o = '0;
    else if (!ads_n_i) addr_o = addr_i;
  end

  assert_latch_closed_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ads_n_i && $past(ads_n_i)) |-> $stable(addr_o));
endmodule

// File: rtl/pdp_sync.sv
module pdp_sync #(
  parameter int W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      q_o    <= '0;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/pdp_fifo.sv
module pdp_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 4,
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [W-1:0]  data_i,
  input  logic          pop_i,
  output logic [W-1:0]  head_o,
  output logic [W-1:0]  next_o,
  output logic [CW-1:0] count_o,
  output logic          full_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [IW-1:0] wr_idx_q, rd_idx_q, rd_nxt;

  function automatic logic [IW-1:0] inc(logic [IW-1:0] v);
    return (v == IW'(DEPTH - 1)) ? '0 : v + 1'b1;
  endfunction

  assign rd_nxt  = inc(rd_idx_q);
  assign head_o  = mem_q[rd_idx_q];
  assign next_o  = mem_q[rd_nxt];
  assign full_o  = (count_o == CW'(DEPTH));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      wr_idx_q <= '0;
      rd_idx_q <= '0;
      count_o  <= '0;
    end else begin
      if (push_i) begin
        mem_q[wr_idx_q] <= data_i;
        wr_idx_q        <= inc(wr_idx_q);
      end
      if (pop_i) rd_idx_q <= rd_nxt;
      count_o <= count_o + CW'(push_i) - CW'(pop_i);
    end
  end

  assert_no_overflow_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> (count_o < CW'(DEPTH)));
  assert_no_underflow_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> (count_o != '0));
endmodule

// File: rtl/pdp_arbiter.sv
module pdp_arbiter
  import pdp_pkg::*;
#(
  parameter int          AW        = 4,
  parameter logic [AW-1:0] DATA_ADDR = AW'(6),
  parameter int          DEPTH     = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ads_n_i,
  input  logic [AW-1:0] addr_i,
  input  logic          rd_n_i,
  input  logic          wr_n_i,
  input  logic          data_cs_n_i,
  input  logic [1:0]    size_i,
  input  logic [31:0]   wdata_i,
  output logic [31:0]   rdata_o,
  output logic          hold_o,
  output logic [31:0]   tx_data_o,
  output logic          tx_valid_o,
  input  logic          tx_ready_i,
  input  logic [31:0]   rx_data_i,
  input  logic          rx_valid_i,
  output logic          rx_ready_o
);
  localparam int DW    = 32;
  localparam int LANES = DW / 8;
  localparam int LW    = $clog2(LANES);
  localparam int CW    = $clog2(DEPTH + 1);

  logic [AW-1:0] lat_addr;
  logic          hit, raw_act, rd_s, wr_s, act_s, rd_op, wr_op;
  logic          done_q, fire, can_wr, can_rd, wwrap;
  logic [LW:0]   nb, wsum, rsum;
  logic [LW-1:0] wptr_q, rptr_q;
  logic [DW-1:0] wacc_q, wmask, rx_head, rx_next, tx_next_unused;
  logic [2*DW-1:0] wwin, rwin;
  logic [CW-1:0] tx_cnt, rx_cnt;
  logic          tx_full, rx_full, tx_push, tx_pop, rx_push, rx_pop;

  pdp_addr_latch #(.AW(AW)) u_latch (
    .clk_i(clk_i), .rst_ni(rst_ni), .ads_n_i(ads_n_i), .addr_i(addr_i), .addr_o(lat_addr)
  );

  pdp_sync #(.W(2)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i({!rd_n_i, !wr_n_i}), .q_o({rd_s, wr_s})
  );

  assign hit     = !data_cs_n_i || (lat_addr == DATA_ADDR);
  assign raw_act = !rd_n_i || !wr_n_i;
  assign act_s   = rd_s || wr_s;
  assign rd_op   = rd_s && !wr_s;
  assign wr_op   = wr_s && !rd_s;
  // leading edge straight from the strobe, trailing edge from the clock
  assign hold_o  = raw_act && hit && !done_q;

  assign nb = data_cs_n_i ? size_bytes(size_i) : (LW+1)'(LANES);

  always_comb begin
    case (nb)
      3'd1:    wmask = 32'h0000_00ff;
      3'd2:    wmask = 32'h0000_ffff;
      default: wmask = '1;
    endcase
  end

  // write packing
  assign wsum   = {1'b0, wptr_q} + nb;
  assign wwrap  = wsum >= (LW+1)'(LANES);
  assign wwin   = {{DW{1'b0}}, wacc_q} | ({{DW{1'b0}}, wdata_i & wmask} << {wptr_q, 3'b000});
  assign can_wr = !wwrap || !tx_full;

  // read unpacking
  assign rsum   = {1'b0, rptr_q} + nb;
  assign rwin   = {rx_next, rx_head} >> {rptr_q, 3'b000};
  assign can_rd = rx_cnt >= ((rsum > (LW+1)'(LANES)) ? CW'(2) : CW'(1));

  assign fire    = hit && !done_q && ((wr_op && can_wr) || (rd_op && can_rd));
  assign tx_push = fire && wr_op && wwrap;
  assign rx_pop  = fire && rd_op && (rsum >= (LW+1)'(LANES));
  assign tx_pop  = tx_valid_o && tx_ready_i;
  assign rx_push = rx_valid_i && rx_ready_o;

  assign tx_valid_o = (tx_cnt != '0);
  assign rx_ready_o = !rx_full;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q  <= 1'b0;
      wptr_q  <= '0;
      rptr_q  <= '0;
      wacc_q  <= '0;
      rdata_o <= '0;
    end else begin
      if (!act_s)    done_q <= 1'b0;
      else if (fire) done_q <= 1'b1;
      if (fire && wr_op) begin
        wptr_q <= wsum[LW-1:0];
        wacc_q <= wwrap ? wwin[2*DW-1:DW] : wwin[DW-1:0];
      end
      if (fire && rd_op) begin
        rptr_q  <= rsum[LW-1:0];
        rdata_o <= rwin[DW-1:0] & wmask;
      end
    end
  end

  pdp_fifo #(.W(DW), .DEPTH(DEPTH)) u_tx (
    .clk_i(clk_i), .rst_ni(rst_ni), .push_i(tx_push), .data_i(wwin[DW-1:0]), .pop_i(tx_pop),
    .head_o(tx_data_o), .next_o(tx_next_unused), .count_o(tx_cnt), .full_o(tx_full)
  );

  pdp_fifo #(.W(DW), .DEPTH(DEPTH)) u_rx (
    .clk_i(clk_i), .rst_ni(rst_ni), .push_i(rx_push), .data_i(rx_data_i), .pop_i(rx_pop),
    .head_o(rx_head), .next_o(rx_next), .count_o(rx_cnt), .full_o(rx_full)
  );

  assert_single_transfer_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |=> !fire);
  assert_cs_keeps_lanes_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && !data_cs_n_i) |=> (wptr_q == $past(wptr_q) && rptr_q == $past(rptr_q)));
  assert_full_write_waits_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_full && !tx_pop && wr_op && wwrap && hit && !done_q) |=> !done_q);
endmodule

// File: tb/sim_pdp_arbiter.sv
module sim_pdp_arbiter;
  localparam logic [3:0] DA = 4'h6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ads_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, cs_n = 1'b1;
  logic [3:0] addr = 4'h0;
  logic [1:0] size = 2'd0;
  logic [31:0] wdata = '0, rdata, tx_data, rx_data = '0;
  logic hold, tx_valid, tx_ready = 1'b0, rx_valid = 1'b0, rx_ready;
  int total = 0, bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  pdp_arbiter #(.AW(4), .DATA_ADDR(DA), .DEPTH(4)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .ads_n_i(ads_n), .addr_i(addr), .rd_n_i(rd_n), .wr_n_i(wr_n),
    .data_cs_n_i(cs_n), .size_i(size), .wdata_i(wdata), .rdata_o(rdata), .hold_o(hold),
    .tx_data_o(tx_data), .tx_valid_o(tx_valid), .tx_ready_i(tx_ready),
    .rx_data_i(rx_data), .rx_valid_i(rx_valid), .rx_ready_o(rx_ready)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic start_acc(input bit is_wr, input bit use_cs, input logic [1:0] sz,
                           input logic [31:0] d, input logic [3:0] a);
    @(negedge clk);
    if (!use_cs) begin
      addr = a; ads_n = 1'b0;
      @(negedge clk);
      ads_n = 1'b1; addr = 4'h0;  // R1: address moves after latch closes
    end
    size = sz; wdata = d; cs_n = !use_cs;
    if (is_wr) wr_n = 1'b0; else rd_n = 1'b0;
    #1;
  endtask

  task automatic wait_release(input string req, output int cyc);
    cyc = 0;
    while (hold && cyc < 60) begin
      @(negedge clk); cyc++;
    end
  endtask

  task automatic end_acc;
    @(negedge clk);
    rd_n = 1'b1; wr_n = 1'b1; cs_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic host_acc(input bit is_wr, input bit use_cs, input logic [1:0] sz,
                          input logic [31:0] d, output logic [31:0] q);
    int c;
    start_acc(is_wr, use_cs, sz, d, DA);
    chk("R2 hold raised", 32'(hold), 32'd1);
    wait_release("R3", c);
    chk("R3 released within 4 cycles", 32'(c >= 1 && c <= 4), 32'd1);
    q = rdata;
    end_acc();
  endtask

  task automatic pop_tx(input string req, input logic [31:0] exp);
    @(negedge clk);
    chk({req, " tx_valid"}, 32'(tx_valid), 32'd1);
    chk({req, " tx_data"}, tx_data, exp);
    tx_ready = 1'b1;
    @(negedge clk);
    tx_ready = 1'b0;
  endtask

  task automatic push_rx(input logic [31:0] d);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = d;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic t_reset;
    chk("R12 hold", 32'(hold), 32'd0);
    chk("R12 tx_valid", 32'(tx_valid), 32'd0);
    chk("R12 rx_ready", 32'(rx_ready), 32'd1);
  endtask

  task automatic t_byte_pack;
    logic [31:0] q;
    int c;
    host_acc(1, 0, 2'd0, 32'h11, q);
    host_acc(1, 0, 2'd0, 32'h22, q);
    host_acc(1, 0, 2'd0, 32'h33, q);
    chk("R4 no push before lane 3", 32'(tx_valid), 32'd0);
    start_acc(1, 0, 2'd0, 32'h44, DA);
    wait_release("R3", c);
    repeat (3) begin
      @(negedge clk);
      chk("R3 hold stays low while strobe held", 32'(hold), 32'd0);
    end
    end_acc();
    pop_tx("R4 packed bytes", 32'h4433_2211);
  endtask

  task automatic t_straddle_write;
    logic [31:0] q;
    host_acc(1, 0, 2'd0, 32'hAA, q);
    host_acc(1, 0, 2'd2, 32'h5566_7788, q);
    host_acc(1, 0, 2'd1, 32'hCCDD, q);
    host_acc(1, 0, 2'd0, 32'hEE, q);
    pop_tx("R5 straddle first", 32'h6677_88AA);
    pop_tx("R5 straddle second", 32'hEECC_DD55);
  endtask

  task automatic t_full_write;
    logic [31:0] q;
    int c;
    for (int i = 1; i <= 4; i++) host_acc(1, 1, 2'd0, 32'hA000_0000 + 32'(i), q); // R9 size ignored
    host_acc(1, 0, 2'd0, 32'h5A, q);  // R6 completes no entry while full
    start_acc(1, 1, 2'd0, 32'hB1B2_B3B4, DA);
    repeat (10) @(negedge clk);
    chk("R6 hold while full", 32'(hold), 32'd1);
    pop_tx("R9 dword via cs", 32'hA000_0001);
    wait_release("R6", c);
    chk("R6 released after drain", 32'(hold), 32'd0);
    end_acc();
    pop_tx("R9 dword via cs", 32'hA000_0002);
    pop_tx("R9 dword via cs", 32'hA000_0003);
    pop_tx("R9 dword via cs", 32'hA000_0004);
    pop_tx("R6 blocked write entry", 32'hB2B3_B45A);
    host_acc(1, 0, 2'd1, 32'h2211, q);
    host_acc(1, 0, 2'd0, 32'h33, q);
    pop_tx("R5 residual merge", 32'h3322_11B1);
    @(negedge clk);
    chk("R11 tx empty", 32'(tx_valid), 32'd0);
  endtask

  task automatic t_reads;
    logic [31:0] q;
    int c;
    push_rx(32'h0403_0201);
    push_rx(32'h1413_1211);
    push_rx(32'h2423_2221);
    push_rx(32'h3433_3231);
    @(negedge clk);
    chk("R11 rx full", 32'(rx_ready), 32'd0);
    host_acc(0, 0, 2'd0, 0, q); chk("R7 lane0", q, 32'h01);
    host_acc(0, 0, 2'd0, 0, q); chk("R7 lane1", q, 32'h02);
    host_acc(0, 0, 2'd0, 0, q); chk("R7 lane2", q, 32'h03);
    chk("R7 no pop before lane 3", 32'(rx_ready), 32'd0);
    host_acc(0, 0, 2'd0, 0, q); chk("R7 lane3", q, 32'h04);
    chk("R7 pop after lane 3", 32'(rx_ready), 32'd1);
    host_acc(0, 0, 2'd0, 0, q); chk("R7 byte", q, 32'h11);
    host_acc(0, 0, 2'd2, 0, q); chk("R8 straddle read", q, 32'h2114_1312);
    host_acc(0, 0, 2'd1, 0, q); chk("R7 halfword", q, 32'h2322);
    host_acc(0, 0, 2'd0, 0, q); chk("R7 last byte", q, 32'h24);
    host_acc(0, 1, 2'd1, 0, q); chk("R9 cs read is dword", q, 32'h3433_3231);
    start_acc(0, 0, 2'd1, 0, DA);
    repeat (10) @(negedge clk);
    chk("R8 hold while empty", 32'(hold), 32'd1);
    push_rx(32'h4443_4241);
    wait_release("R8", c);
    chk("R8 released after arrival", 32'(hold), 32'd0);
    chk("R8 data after wait", rdata, 32'h4241);
    end_acc();
    host_acc(0, 0, 2'd1, 0, q); chk("R7 upper half", q, 32'h4443);
  endtask

  task automatic t_nonhit;
    logic [31:0] q;
    start_acc(1, 0, 2'd2, 32'hDEAD_BEEF, 4'h1);
    chk("R10 no hold on other address", 32'(hold), 32'd0);
    repeat (6) @(negedge clk);
    chk("R10 hold still low", 32'(hold), 32'd0);
    chk("R10 no tx push", 32'(tx_valid), 32'd0);
    end_acc();
    host_acc(1, 0, 2'd2, 32'h0BAD_F00D, q);
    pop_tx("R10 lane pointer untouched", 32'h0BAD_F00D);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_byte_pack();
    t_straddle_write();
    t_full_write();
    t_reads();
    t_nonhit();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL R3: watchdog expired actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule